// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This block drives a 12-bit successive-approximation converter that has a convert-start line and a four-wire SPI-style serial port. A one-cycle start strobe makes the controller raise the convert-start line. The controller then waits the worst-case conversion time, measured in system-clock cycles, and runs one serial frame. In that frame it clocks the converted sample in from the converter. On the same clocks it shifts out the 6-bit configuration word that the converter will apply to its next conversion.

Two power policies are selectable per conversion. In awake mode the convert-start line is pulsed high for a single cycle, which is well inside the short window allowed after the rising edge, so the converter stays powered. In sleep mode the line is held high through the whole conversion time and dropped only when the readout begins, so the converter powers down between samples. The result word is sign-extended to 16 bits when the converter was in bipolar mode and zero-extended when it was in unipolar mode. That mode is the unipolar bit of the configuration word that was in force for the conversion being read, which is the word sent in the previous frame.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, convStart, sclk, adcSdi, resultValid and result are all 0, and the result format is bipolar.
- R2: A startReq seen while idle raises convStart on the next cycle. A startReq seen during a conversion, a serial frame or the acquisition gap is ignored, and convStart shows no new rising edge.
- R3: With sleepMode = 0 latched at the start, convStart is high for exactly one clock cycle. This is no longer than WINDOW_CYC.
- R4: With sleepMode = 1 latched at the start, convStart stays high for exactly CONV_CYC cycles. It falls as the readout begins.
- R5: The first sclk rising edge comes exactly CONV_CYC + HALF_CYC cycles after the convStart rising edge. Each later rising edge follows the previous one by 2*HALF_CYC cycles. There are exactly 12 rising edges per frame, and sclk is never high while convStart is high.
- R6: At the k-th sclk rising edge (k = 1..6), adcSdi carries cfgWord[6-k], so cfgWord[5] (single-ended/differential select) goes first. At rising edges 7 to 12, adcSdi is 0. cfgWord and sleepMode are captured on the start cycle, and changing them afterwards has no effect on that frame.
- R7: adcSdo is sampled at each sclk rising edge, most significant bit first, and the 12 samples form the result.
- R8: cfgWord[1] is the unipolar select. When the previous frame sent cfgWord[1] = 1, result holds the 12 bits zero-extended to 16. Otherwise it holds them sign-extended as two's complement.
- R9: resultValid is a single-cycle pulse. It is high in the cycle right after the edge that captures the 12th bit, and result holds its value until the next pulse.
- R10: At least ACQ_CYC + 1 cycles separate the final sclk falling edge of a frame from the next convStart rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to begin a conversion |
| cfgWord | input | 6 | Configuration word for the next conversion; bit 5 is sent first, bit 1 selects unipolar |
| sleepMode | input | 1 | 1 = hold convStart high and let the converter sleep, 0 = keep it awake |
| adcSdo | input | 1 | Serial data from the converter |
| convStart | output | 1 | Convert-start line to the converter |
| sclk | output | 1 | Serial clock to the converter |
| adcSdi | output | 1 | Serial configuration data to the converter |
| result | output | 16 | Last converted sample, sign- or zero-extended |
| resultValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench models the converter at its pins. It times every convStart high period, counts the cycles from the rising edge to each serial clock edge, and records the bit presented at each rising edge, so an off-by-one in the conversion wait or a half period sampled on the wrong edge shows up as a cycle mismatch. The frame sequence alternates the unipolar bit and the power policy, and drives extreme codes such as 0x800, 0xFFF and 0x7FF. A design that formatted a result with the configuration it had just sent, rather than the one already in force, would return wrong upper bits. Start requests are injected during the readout and during the acquisition gap; a controller that restarted would show a second convStart rising edge. The configuration and mode inputs are also changed right after the start, which catches a design that samples them late.

// File: rtl/adcr_pkg.sv
`timescale 1ns/1ps
package adcr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_ACQ   = 2'd3
  } ctrlState_t;

  // strobes from the sequencer to the datapath, valid for one cycle
  typedef struct packed {
    logic startConv;  // raise convert-start, capture configuration
    logic dropConv;   // lower convert-start
    logic sclkRise;   // raise serial clock, sample data in
    logic sclkFall;   // lower serial clock, advance data out
    logic lastBit;    // current bit is the final one of the frame
  } ctrlStrobe_t;

endpackage

// File: rtl/adcr_ctrl.sv
`timescale 1ns/1ps
module adcr_ctrl
  import adcr_pkg::*;
#(
  parameter int CONV_CYC  = 400,
  parameter int ACQ_CYC   = 60,
  parameter int HALF_CYC  = 4,
  parameter int FRAME_LEN = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        sleepMode,
  output ctrlStrobe_t strb
);

  localparam int PERIOD   = 2 * HALF_CYC;
  localparam int MAX_A    = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
  localparam int MAX_WAIT = (MAX_A > PERIOD) ? MAX_A : PERIOD;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int BIT_W    = $clog2(FRAME_LEN + 1);

  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] PER_LAST  = CNT_W'(PERIOD - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_LEN - 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             sleepLat;

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE:  strb.startConv = startReq;
      ST_CONV:  strb.dropConv  = sleepLat ? (cnt == CONV_LAST) : (cnt == '0);
      ST_SHIFT: begin
        strb.sclkRise = (cnt == HALF_LAST);
        strb.sclkFall = (cnt == PER_LAST);
        strb.lastBit  = (bitIdx == BIT_LAST);
      end
      default:  strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      sleepLat <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state    <= ST_CONV;
          cnt      <= '0;
          sleepLat <= sleepMode;
        end
        ST_CONV: if (cnt == CONV_LAST) begin
          state  <= ST_SHIFT;
          cnt    <= '0;
          bitIdx <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_SHIFT: if (cnt == PER_LAST) begin
          cnt <= '0;
          if (bitIdx == BIT_LAST) state <= ST_ACQ;
          else                    bitIdx <= bitIdx + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_ACQ: if (cnt == ACQ_LAST) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // independent tally of issued rising strobes per frame
  logic [BIT_W-1:0] riseTally;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             riseTally <= '0;
    else if (strb.startConv) riseTally <= '0;
    else if (strb.sclkRise)  riseTally <= riseTally + 1'b1;
  end

  // R5: every frame delivers the full count of rising edges before acquisition
  a_r5_rise_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ) |-> (riseTally == BIT_W'(FRAME_LEN)));

  // R2: once a conversion begins, the sequencer leaves idle and stays busy
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    strb.startConv |=> (state == ST_CONV));

endmodule

// File: rtl/adcr_datapath.sv
`timescale 1ns/1ps
module adcr_datapath
  import adcr_pkg::*;
#(
  parameter int CFG_W      = 6,
  parameter int DATA_W     = 12,
  parameter int OUT_W      = 16,
  parameter int FRAME_LEN  = 12,
  parameter int UNI_BIT    = 1,
  parameter int CONV_CYC   = 400,
  parameter int WINDOW_CYC = 10,
  parameter int MIN_GAP    = 556
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              adcSdo,
  output logic              convStart,
  output logic              sclk,
  output logic              adcSdi,
  output logic [OUT_W-1:0]  result,
  output logic              resultValid
);

  logic                 convStartQ;
  logic                 sclkQ;
  logic [FRAME_LEN-1:0] txReg;
  logic [DATA_W-2:0]    rxReg;
  logic                 uniPending;
  logic                 uniActive;
  logic [OUT_W-1:0]     resultQ;
  logic                 validQ;

  logic [DATA_W-1:0]    fullWord;
  logic [OUT_W-1:0]     fmtWord;

  assign fullWord = {rxReg, adcSdo};

  generate
    if (OUT_W > DATA_W) begin : g_ext
      assign fmtWord = uniActive
        ? {{(OUT_W-DATA_W){1'b0}}, fullWord}
        : {{(OUT_W-DATA_W){fullWord[DATA_W-1]}}, fullWord};
    end else begin : g_flat
      assign fmtWord = fullWord;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convStartQ <= 1'b0;
      sclkQ      <= 1'b0;
      txReg      <= '0;
      rxReg      <= '0;
      uniPending <= 1'b0;
      uniActive  <= 1'b0;
      resultQ    <= '0;
      validQ     <= 1'b0;
    end else begin
      validQ <= strb.sclkRise && strb.lastBit;
      if (strb.startConv) begin
        convStartQ <= 1'b1;
        uniPending <= cfgWord[UNI_BIT];
        txReg      <= {cfgWord, {(FRAME_LEN-CFG_W){1'b0}}};
      end
      if (strb.dropConv) convStartQ <= 1'b0;
      if (strb.sclkRise) begin
        sclkQ <= 1'b1;
        rxReg <= fullWord[DATA_W-2:0];
        if (strb.lastBit) begin
          resultQ   <= fmtWord;
          uniActive <= uniPending;
        end
      end
      if (strb.sclkFall) begin
        sclkQ <= 1'b0;
        txReg <= txReg << 1;
      end
    end
  end

  assign convStart   = convStartQ;
  assign sclk        = sclkQ;
  assign adcSdi      = txReg[FRAME_LEN-1];
  assign result      = resultQ;
  assign resultValid = validQ;

  // ---- checker state: high-time and rise-spacing counters ----
  localparam int HI_W  = $clog2(CONV_CYC + 1);
  localparam int GAP_W = $clog2(MIN_GAP + 1);

  logic [HI_W-1:0]  hiLen;
  logic [GAP_W-1:0] sinceRise;
  logic             csPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiLen     <= '0;
      sinceRise <= GAP_W'(MIN_GAP);
      csPrev    <= 1'b0;
    end else begin
      csPrev <= convStartQ;
      if (!convStartQ)                    hiLen <= '0;
      else if (hiLen != HI_W'(CONV_CYC))  hiLen <= hiLen + 1'b1;
      if (convStartQ && !csPrev)              sinceRise <= '0;
      else if (sinceRise != GAP_W'(MIN_GAP))  sinceRise <= sinceRise + 1'b1;
    end
  end

  // R3/R4: the line never drops between the early window and end of conversion
  a_r4_drop_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convStartQ) |-> ((hiLen <= HI_W'(WINDOW_CYC)) || (hiLen >= HI_W'(CONV_CYC))));

  // R10: no new conversion before conversion, frame and acquisition have passed
  a_r10_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convStartQ) |-> (sinceRise == GAP_W'(MIN_GAP)));

  // R5: serial clock stays low while convert-start is high
  a_r5_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sclkQ |-> !convStartQ);

  // R9: valid is a single-cycle pulse
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    validQ |=> !validQ);

  // R8: bipolar results are sign-extended, unipolar ones zero-extended
  a_r8_bipolar_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (validQ && !$past(uniActive)) |-> (resultQ == OUT_W'($signed(resultQ[DATA_W-1:0]))));
  a_r8_unipolar_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (validQ && $past(uniActive)) |-> (resultQ == OUT_W'(resultQ[DATA_W-1:0])));

endmodule

// File: rtl/adc_readout_ctrl.sv
`timescale 1ns/1ps
module adc_readout_ctrl
  import adcr_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CFG_W      = 6,
  parameter int OUT_W      = 16,
  parameter int UNI_BIT    = 1,
  parameter int CONV_CYC   = 400,
  parameter int ACQ_CYC    = 60,
  parameter int HALF_CYC   = 4,
  parameter int WINDOW_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             sleepMode,
  input  logic             adcSdo,
  output logic             convStart,
  output logic             sclk,
  output logic             adcSdi,
  output logic [OUT_W-1:0] result,
  output logic             resultValid
);

  localparam int FRAME_LEN = (DATA_W > CFG_W) ? DATA_W : CFG_W;
  localparam int MIN_GAP   = CONV_CYC + 2 * HALF_CYC * FRAME_LEN + ACQ_CYC;

  ctrlStrobe_t strb;

  adcr_ctrl #(
    .CONV_CYC (CONV_CYC),
    .ACQ_CYC  (ACQ_CYC),
    .HALF_CYC (HALF_CYC),
    .FRAME_LEN(FRAME_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .sleepMode(sleepMode),
    .strb     (strb)
  );

  adcr_datapath #(
    .CFG_W     (CFG_W),
    .DATA_W    (DATA_W),
    .OUT_W     (OUT_W),
    .FRAME_LEN (FRAME_LEN),
    .UNI_BIT   (UNI_BIT),
    .CONV_CYC  (CONV_CYC),
    .WINDOW_CYC(WINDOW_CYC),
    .MIN_GAP   (MIN_GAP)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .cfgWord    (cfgWord),
    .adcSdo     (adcSdo),
    .convStart  (convStart),
    .sclk       (sclk),
    .adcSdi     (adcSdi),
    .result     (result),
    .resultValid(resultValid)
  );

endmodule

// File: tb/adc_readout_ctrl_tb.sv
`timescale 1ns/1ps
module adc_readout_ctrl_tb;

  localparam int CONV = 400;
  localparam int ACQ  = 60;
  localparam int HALF = 4;
  localparam int WIN  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startReq = 1'b0;
  logic [5:0]  cfgWord = '0;
  logic        sleepMode = 1'b0;
  logic        adcSdo;
  logic        convStart, sclk, adcSdi, resultValid;
  logic [15:0] result;

  always #2 clk = ~clk;

  adc_readout_ctrl #(
    .CONV_CYC(CONV), .ACQ_CYC(ACQ), .HALF_CYC(HALF), .WINDOW_CYC(WIN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cfgWord(cfgWord),
    .sleepMode(sleepMode), .adcSdo(adcSdo), .convStart(convStart),
    .sclk(sclk), .adcSdi(adcSdi), .result(result), .resultValid(resultValid)
  );

  int  vecs = 0;
  int  fails = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  // ---- converter model and per-cycle protocol comparison ----
  logic [11:0] curSample;
  logic [5:0]  curCfg;
  bit          curSleep;
  bit          expUni, inFrame, prevCs, prevSclk, prevValid;
  int          cyc, riseCyc, lastFallCyc, lastSclkRise, riseCount, bitPos;

  always @(negedge clk) begin
    if (!rst_n) begin
      adcSdo = 1'b0; expUni = 0; inFrame = 0; prevCs = 0; prevSclk = 0;
      prevValid = 0; cyc = 0; riseCyc = 0; lastFallCyc = -100000;
      lastSclkRise = 0; riseCount = 0; bitPos = 0;
    end else begin
      cyc++;
      if (convStart && !prevCs) begin
        chk(!inFrame && (cyc - lastFallCyc > ACQ), "R10 rise spacing", cyc - lastFallCyc, ACQ + 1);
        inFrame = 1; riseCyc = cyc; riseCount = 0; bitPos = 0;
        adcSdo = curSample[11];
      end
      if (!convStart && prevCs)
        chk((cyc - riseCyc) == (curSleep ? CONV : 1), curSleep ? "R4 high time" : "R3 high time",
            cyc - riseCyc, curSleep ? CONV : 1);
      if (sclk && !prevSclk) begin
        riseCount++;
        lastSclkRise = cyc;
        chk(cyc == riseCyc + CONV + HALF + (riseCount - 1) * 2 * HALF, "R5 sclk edge time",
            cyc - riseCyc, CONV + HALF + (riseCount - 1) * 2 * HALF);
        chk(!convStart && riseCount <= 12, "R5 sclk count/quiet", riseCount, 12);
        if (riseCount <= 6) chk(adcSdi == curCfg[6 - riseCount], "R6 cfg bit", adcSdi, curCfg[6 - riseCount]);
        else                chk(adcSdi == 1'b0, "R6 trailing zero", adcSdi, 0);
      end
      if (!sclk && prevSclk) begin
        bitPos++;
        if (bitPos < 12) adcSdo = curSample[11 - bitPos];
        if (riseCount == 12) begin inFrame = 0; lastFallCyc = cyc; end
      end
      if (resultValid) begin
        automatic logic [15:0] expRes = expUni ? {4'h0, curSample} : {{4{curSample[11]}}, curSample};
        chk(!prevValid, "R9 single pulse", prevValid, 0);
        chk(riseCount == 12 && lastSclkRise == cyc, "R9 valid timing", cyc - lastSclkRise, 0);
        chk(result == expRes, expUni ? "R7 R8 unipolar result" : "R7 R8 bipolar result", result, expRes);
        expUni = curCfg[1];
      end
      prevCs = convStart; prevSclk = sclk; prevValid = resultValid;
    end
  end

  // ---- watchdog ----
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk(0, "watchdog expired", wd, 150000);
      finishRun();
    end
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic doFrame(input logic [5:0] cfg, input bit slp, input logic [11:0] smp,
                         input bit pokeShift, input bit pokeAcq);
    curCfg = cfg; curSleep = slp; curSample = smp;
    cfgWord = cfg; sleepMode = slp;
    pulseStart();
    chk(convStart == 1'b1, "R2 start accepted", convStart, 1);
    cfgWord = ~cfg; sleepMode = ~slp;   // late changes must not matter (R6)
    if (pokeShift) begin
      repeat (CONV + 20) @(negedge clk);
      pulseStart();
      chk(convStart == 1'b0, "R2 start ignored in frame", convStart, 0);
    end
    while (!resultValid) @(negedge clk);
    @(negedge clk);
    chk(resultValid == 1'b0 && result == (expUni == curCfg[1] ? result : result), "R9 pulse ends", resultValid, 0);
    if (pokeAcq) begin
      repeat (5) @(negedge clk);
      pulseStart();
      chk(convStart == 1'b0, "R2 start ignored in gap", convStart, 0);
    end
    repeat (ACQ + 4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(convStart == 0 && sclk == 0 && adcSdi == 0, "R1 reset pins", {convStart, sclk, adcSdi}, 0);
    chk(resultValid == 0 && result == 16'h0, "R1 reset result", result, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(convStart == 0 && sclk == 0, "R1 idle after reset", {convStart, sclk}, 0);

    doFrame(6'b100000, 0, 12'h7FF, 0, 0);
    doFrame(6'b100010, 1, 12'h800, 0, 0);
    doFrame(6'b010011, 0, 12'hFFF, 1, 0);
    doFrame(6'b101101, 1, 12'hA5C, 0, 1);
    doFrame(6'b011110, 0, 12'h9C3, 1, 1);
    doFrame(6'b000000, 1, 12'h000, 0, 0);
    doFrame(6'b111111, 0, 12'h001, 0, 0);
    doFrame(6'b010101, 1, 12'h3E8, 0, 0);
    for (int i = 0; i < 10; i++)
      doFrame(6'((i * 23) ^ 6'h15), i[0], 12'((i * 12'h5A7) ^ 12'hC3A), i[1], i[2]);

    chk(convStart == 0 && sclk == 0, "R2 idle at end", {convStart, sclk}, 0);
    finishRun();
  end

endmodule